// File: doc/BRIEF.md
# Registered Bidirectional Bus Transceiver

This block joins two 8-bit bidirectional buses, called A and B, and holds one storage register for each of them. Each bus appears at the block edge as a separate input, output and output-enable, so no tristate logic lives inside the chip. The pad ring or the bus fabric combines the three signals. An active-low enable and a direction input decide which side, if either, is driven. Two select inputs, one for each direction, decide whether the driven side shows the live value of the opposite bus or the value stored from it.

Each register loads its own bus on a clock edge when its capture strobe is high. The strobes work whatever the enable and direction settings are, so the block can sample one or both buses while both sides are released. A parameter makes every data path from an input to the opposite output either inverting or non-inverting. The stored value is always the raw bus level. When inversion is selected, it is applied only on the way out.

All pins are plain control and data pins with no handshake. The buses carry levels rather than transfers, so there is no back-pressure to describe. A live value reaches the opposite output in the same cycle. A stored value is visible from the cycle after its capture edge.

Top module: `xcvr_regbus`

## Requirements
- R1: While `rst_n` is low at a rising edge of `clk`, both registers clear to zero. A later stored-mode output then reads 0x00 in the non-inverting variant and 0xFF in the inverting variant.
- R2: A register loads only at a rising edge of `clk` with its strobe high (`cap_a` for the A register from `a_in`, `cap_b` for the B register from `b_in`). With the strobe low, it keeps its value whatever its bus input does.
- R3: With `oe_n` high, `a_oe` and `b_oe` are both 0. Whenever an output-enable is 0, the matching output data bus reads all zeros.
- R4: With `oe_n` low, `dir` = 1 sets `b_oe` = 1 and `a_oe` = 0, and `dir` = 0 sets `a_oe` = 1 and `b_oe` = 0. The two enables are never 1 together, and they depend on `oe_n` and `dir` alone, with no clock delay.
- R5: With B driven and `sel_ab` = 0, `b_out` follows `a_in` in the same cycle.
- R6: With B driven and `sel_ab` = 1, `b_out` shows the A register.
- R7: With A driven, `sel_ba` = 0 makes `a_out` follow `b_in` in the same cycle, and `sel_ba` = 1 makes `a_out` show the B register.
- R8: With `INVERT` = 1, every driven output is the bitwise complement of the value that `INVERT` = 0 would give. With `INVERT` = 0, no path inverts.
- R9: If a side is driven in stored mode and its source register captures at an edge, the output shows the old value before that edge and the newly captured value from that edge on.
- R10: With `oe_n` high, both strobes may capture at the same edge. Both stored values can then be read once the block is enabled.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock for both registers |
| rst_n | input | 1 | Active-low synchronous reset of both registers |
| oe_n | input | 1 | Active-low transceiver enable; high isolates both sides |
| dir | input | 1 | 1 drives side B, 0 drives side A |
| sel_ab | input | 1 | Source toward B: 0 live A, 1 stored A |
| sel_ba | input | 1 | Source toward A: 0 live B, 1 stored B |
| cap_a | input | 1 | Capture strobe for the A register |
| cap_b | input | 1 | Capture strobe for the B register |
| a_in | input | W | Level seen on bus A |
| a_out | output | W | Data driven onto bus A |
| a_oe | output | 1 | Drive enable for bus A |
| b_in | input | W | Level seen on bus B |
| b_out | output | W | Data driven onto bus B |
| b_oe | output | 1 | Drive enable for bus B |

## Verification
The bench builds two copies of the block side by side: one with `W` = 8 and `INVERT` = 0, and one with `W` = 8 and `INVERT` = 1. Both copies receive the same stimulus. Each expected item holds the results for both polarities, so every check of a live path, a stored path or the value after reset also checks that the inverting variant gives the exact complement. An eight-bit width lets all-zeros, all-ones and alternating-bit patterns test that each bit is passed or flipped on its own, with no shift or swap.

// File: rtl/xcvr_pkg.sv
package xcvr_pkg;

  // Which side of the transceiver is currently being driven.
  typedef enum logic [1:0] {
    DRIVE_NONE = 2'd0,
    DRIVE_A    = 2'd1,
    DRIVE_B    = 2'd2
  } drive_e;

endpackage

// File: rtl/xcvr_store.sv
// One capture register: it loads its bus level on a strobed clock edge.
module xcvr_store #(
  parameter int W = 8
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         cap,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      q <= '0;
    end else if (cap) begin
      q <= d;
    end
  end

endmodule

// File: rtl/xcvr_ctrl.sv
// Decodes the enable and direction inputs into the side to be driven.
module xcvr_ctrl
  import xcvr_pkg::*;
(
  input  logic   oe_n,
  input  logic   dir,
  output drive_e drive
);

  always_comb begin
    if (oe_n) begin
      drive = DRIVE_NONE;
    end else if (dir) begin
      drive = DRIVE_B;
    end else begin
      drive = DRIVE_A;
    end
  end

endmodule

// File: rtl/xcvr_route.sv
// Output path for one side: choose live or stored data, apply the
// polarity, and force zeros while the side is not driven.
module xcvr_route #(
  parameter int W      = 8,
  parameter bit INVERT = 1'b0
) (
  input  logic [W-1:0] live,
  input  logic [W-1:0] held,
  input  logic         use_held,
  input  logic         en,
  output logic [W-1:0] out
);

  logic [W-1:0] picked;
  logic [W-1:0] shaped;

  assign picked = use_held ? held : live;

  generate
    if (INVERT) begin : g_inv
      assign shaped = ~picked;
    end else begin : g_pass
      assign shaped = picked;
    end
  endgenerate

  assign out = en ? shaped : '0;

endmodule

// File: rtl/xcvr_regbus.sv
module xcvr_regbus
  import xcvr_pkg::*;
#(
  parameter int W      = 8,
  parameter bit INVERT = 1'b0
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         oe_n,
  input  logic         dir,
  input  logic         sel_ab,
  input  logic         sel_ba,
  input  logic         cap_a,
  input  logic         cap_b,
  input  logic [W-1:0] a_in,
  output logic [W-1:0] a_out,
  output logic         a_oe,
  input  logic [W-1:0] b_in,
  output logic [W-1:0] b_out,
  output logic         b_oe
);

  logic [W-1:0] reg_a;
  logic [W-1:0] reg_b;
  drive_e       drive;

  xcvr_store #(.W(W)) u_store_a (
    .clk(clk), .rst_n(rst_n), .cap(cap_a), .d(a_in), .q(reg_a)
  );

  xcvr_store #(.W(W)) u_store_b (
    .clk(clk), .rst_n(rst_n), .cap(cap_b), .d(b_in), .q(reg_b)
  );

  xcvr_ctrl u_ctrl (
    .oe_n(oe_n), .dir(dir), .drive(drive)
  );

  assign a_oe = (drive == DRIVE_A);
  assign b_oe = (drive == DRIVE_B);

  // Toward B: live A or stored A.
  xcvr_route #(.W(W), .INVERT(INVERT)) u_route_b (
    .live(a_in), .held(reg_a), .use_held(sel_ab), .en(b_oe), .out(b_out)
  );

  // Toward A: live B or stored B.
  xcvr_route #(.W(W), .INVERT(INVERT)) u_route_a (
    .live(b_in), .held(reg_b), .use_held(sel_ba), .en(a_oe), .out(a_out)
  );

endmodule

// File: rtl/xcvr_regbus_chk.sv
module xcvr_regbus_chk #(
  parameter int W      = 8,
  parameter bit INVERT = 1'b0
) (
  input logic         clk,
  input logic         rst_n,
  input logic         oe_n,
  input logic         dir,
  input logic         sel_ab,
  input logic         sel_ba,
  input logic         cap_a,
  input logic         cap_b,
  input logic [W-1:0] a_in,
  input logic [W-1:0] a_out,
  input logic         a_oe,
  input logic [W-1:0] b_in,
  input logic [W-1:0] b_out,
  input logic         b_oe
);

  localparam logic [W-1:0] FLIP = INVERT ? {W{1'b1}} : {W{1'b0}};

  AST_ONE_DRIVER: assert property (@(posedge clk) disable iff (!rst_n)
    !(a_oe && b_oe)); // R4
  AST_DIR_TO_B: assert property (@(posedge clk) disable iff (!rst_n)
    (!oe_n && dir) |-> (b_oe && !a_oe)); // R4
  AST_DIR_TO_A: assert property (@(posedge clk) disable iff (!rst_n)
    (!oe_n && !dir) |-> (a_oe && !b_oe)); // R4
  AST_ISOLATED: assert property (@(posedge clk) disable iff (!rst_n)
    oe_n |-> (!a_oe && !b_oe)); // R3
  AST_IDLE_A_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    !a_oe |-> (a_out == '0)); // R3
  AST_IDLE_B_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    !b_oe |-> (b_out == '0)); // R3
  AST_LATCH_A: assert property (@(posedge clk) disable iff (!rst_n)
    cap_a |=> (!(b_oe && sel_ab) || (b_out == ($past(a_in) ^ FLIP)))); // R6
  AST_LATCH_B: assert property (@(posedge clk) disable iff (!rst_n)
    cap_b |=> (!(a_oe && sel_ba) || (a_out == ($past(b_in) ^ FLIP)))); // R7
  AST_HOLD_A: assert property (@(posedge clk) disable iff (!rst_n)
    (!cap_a && b_oe && sel_ab) |=> (!(b_oe && sel_ab) || $stable(b_out))); // R2
  AST_HOLD_B: assert property (@(posedge clk) disable iff (!rst_n)
    (!cap_b && a_oe && sel_ba) |=> (!(a_oe && sel_ba) || $stable(a_out))); // R2

endmodule

bind xcvr_regbus xcvr_regbus_chk #(.W(W), .INVERT(INVERT)) u_chk (
  .clk(clk), .rst_n(rst_n), .oe_n(oe_n), .dir(dir),
  .sel_ab(sel_ab), .sel_ba(sel_ba), .cap_a(cap_a), .cap_b(cap_b),
  .a_in(a_in), .a_out(a_out), .a_oe(a_oe),
  .b_in(b_in), .b_out(b_out), .b_oe(b_oe)
);

// File: tb/sim_xcvr_regbus.sv
module sim_xcvr_regbus;

  localparam int W = 8;
  localparam logic [W-1:0] ONES = {W{1'b1}};

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic oe_n = 1'b1;
  logic dir = 1'b0;
  logic sel_ab = 1'b0;
  logic sel_ba = 1'b0;
  logic cap_a = 1'b0;
  logic cap_b = 1'b0;
  logic [W-1:0] a_in = '0;
  logic [W-1:0] b_in = '0;

  logic [W-1:0] a_out0, b_out0, a_out1, b_out1;
  logic a_oe0, b_oe0, a_oe1, b_oe1;

  always #4 clk = ~clk;  // 125 MHz

  xcvr_regbus #(.W(W), .INVERT(1'b0)) u0 (
    .clk(clk), .rst_n(rst_n), .oe_n(oe_n), .dir(dir),
    .sel_ab(sel_ab), .sel_ba(sel_ba), .cap_a(cap_a), .cap_b(cap_b),
    .a_in(a_in), .a_out(a_out0), .a_oe(a_oe0),
    .b_in(b_in), .b_out(b_out0), .b_oe(b_oe0)
  );

  xcvr_regbus #(.W(W), .INVERT(1'b1)) u1 (
    .clk(clk), .rst_n(rst_n), .oe_n(oe_n), .dir(dir),
    .sel_ab(sel_ab), .sel_ba(sel_ba), .cap_a(cap_a), .cap_b(cap_b),
    .a_in(a_in), .a_out(a_out1), .a_oe(a_oe1),
    .b_in(b_in), .b_out(b_out1), .b_oe(b_oe1)
  );

  typedef struct {
    logic         a_en;
    logic         b_en;
    logic [W-1:0] a_plain;
    logic [W-1:0] b_plain;
    logic [W-1:0] a_flip;
    logic [W-1:0] b_flip;
    string        tag;
  } exp_t;

  exp_t exp_q[$];
  int   n_cmp = 0;
  int   n_bad = 0;
  bit   done  = 1'b0;

  // Reference registers kept by the bench itself.
  logic [W-1:0] mdl_a = '0;
  logic [W-1:0] mdl_b = '0;

  task automatic step(input logic r, input logic g, input logic d,
                      input logic sab, input logic sba,
                      input logic ca, input logic cb,
                      input logic [W-1:0] ai, input logic [W-1:0] bi,
                      input string tag);
    exp_t e;
    logic [W-1:0] va, vb;
    @(negedge clk);
    rst_n = r; oe_n = g; dir = d; sel_ab = sab; sel_ba = sba;
    cap_a = ca; cap_b = cb; a_in = ai; b_in = bi;
    vb = sab ? mdl_a : ai;
    va = sba ? mdl_b : bi;
    e.tag  = tag;
    e.a_en = !g && !d;
    e.b_en = !g && d;
    e.a_plain = e.a_en ? va : '0;
    e.b_plain = e.b_en ? vb : '0;
    e.a_flip  = e.a_en ? ~va : '0;
    e.b_flip  = e.b_en ? ~vb : '0;
    exp_q.push_back(e);
    @(posedge clk);
    if (!r) begin
      mdl_a = '0;
      mdl_b = '0;
    end else begin
      if (ca) mdl_a = ai;
      if (cb) mdl_b = bi;
    end
  endtask

  // Monitor: pop one expected item per cycle and compare both copies.
  always begin
    @(negedge clk);
    #2;
    if (exp_q.size() != 0) begin
      exp_t e;
      e = exp_q.pop_front();
      n_cmp++;
      if (a_oe0 !== e.a_en || b_oe0 !== e.b_en || a_oe1 !== e.a_en ||
          b_oe1 !== e.b_en || a_out0 !== e.a_plain || b_out0 !== e.b_plain ||
          a_out1 !== e.a_flip || b_out1 !== e.b_flip) begin
        n_bad++;
        $display("FAIL %s: got oe=%b%b/%b%b a=%h/%h b=%h/%h exp oe=%b%b a=%h/%h b=%h/%h",
                 e.tag, a_oe0, b_oe0, a_oe1, b_oe1, a_out0, a_out1, b_out0, b_out1,
                 e.a_en, e.b_en, e.a_plain, e.a_flip, e.b_plain, e.b_flip);
      end
    end
  end

  initial begin
    // Reset, isolated.
    step(0, 1, 0, 0, 0, 0, 0, 8'h3C, 8'hC3, "R1 reset isolated");
    step(0, 1, 1, 1, 1, 1, 1, 8'h77, 8'h11, "R1 reset ignores strobes");
    // Stored value right after reset.
    step(1, 0, 1, 1, 0, 0, 0, 8'hE1, 8'h00, "R1 stored A after reset");
    step(1, 0, 0, 0, 1, 0, 0, 8'h00, 8'h96, "R1 stored B after reset");
    // Isolation with varied data.
    step(1, 1, 1, 0, 0, 0, 0, 8'hFF, 8'hFF, "R3 isolated dir=1");
    step(1, 1, 0, 1, 1, 0, 0, 8'h81, 8'h42, "R3 isolated dir=0");
    // Live A to B.
    step(1, 0, 1, 0, 0, 0, 0, 8'h5A, 8'h00, "R5 live A->B 5A R8");
    step(1, 0, 1, 0, 0, 0, 0, 8'hA5, 8'h0F, "R5 live A->B A5 R4");
    step(1, 0, 1, 0, 0, 0, 0, 8'h00, 8'hF0, "R5 live A->B 00");
    // Live B to A.
    step(1, 0, 0, 0, 0, 0, 0, 8'h12, 8'hC9, "R7 live B->A C9 R4");
    step(1, 0, 0, 0, 0, 0, 0, 8'h34, 8'hFF, "R7 live B->A FF");
    // Capture A while driving A, then replay toward B.
    step(1, 0, 0, 0, 0, 1, 0, 8'h6D, 8'h01, "R2 capture A while A driven");
    step(1, 0, 1, 1, 0, 0, 0, 8'h00, 8'h02, "R6 stored A replay 6D");
    // Strobe low: bus change must not reach the register.
    step(1, 0, 1, 1, 0, 0, 0, 8'hFF, 8'h03, "R2 no strobe keeps A");
    // Capture in stored mode: old value this cycle, new value next.
    step(1, 0, 1, 1, 0, 1, 0, 8'hB4, 8'h04, "R9 capture same cycle old");
    step(1, 0, 1, 1, 0, 0, 0, 8'h0B, 8'h05, "R9 capture shows new B4");
    // Stored B replay.
    step(1, 0, 0, 0, 0, 0, 1, 8'h00, 8'h3E, "R2 capture B while A live");
    step(1, 0, 0, 0, 1, 0, 0, 8'h00, 8'hAA, "R7 stored B replay 3E");
    step(1, 0, 0, 0, 1, 0, 1, 8'h00, 8'h55, "R9 B capture same cycle old");
    step(1, 0, 0, 0, 1, 0, 0, 8'h00, 8'h99, "R9 B shows new 55");
    // Isolated capture of both, then reveal.
    step(1, 1, 0, 0, 0, 1, 1, 8'hC7, 8'h2D, "R10 isolated dual capture");
    step(1, 0, 1, 1, 1, 0, 0, 8'h00, 8'h00, "R10 reveal stored A C7");
    step(1, 0, 0, 1, 1, 0, 0, 8'hFF, 8'hFF, "R10 reveal stored B 2D");
    // Mid-run reset clears stored data.
    step(0, 1, 0, 0, 0, 0, 0, 8'h00, 8'h00, "R1 mid-run reset");
    step(1, 0, 1, 1, 1, 0, 0, 8'h5F, 8'hF5, "R1 A cleared by reset R8");
    step(1, 0, 0, 1, 1, 0, 0, 8'h5F, 8'hF5, "R1 B cleared by reset");
    @(negedge clk);
    #4;
    done = 1'b1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

  initial begin
    #(8 * 200000);
    if (!done) begin
      n_cmp++;
      n_bad++;
      $display("FAIL watchdog: got timeout exp completion");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
    end
  end

endmodule